// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers thirty-two level-sensitive request lines, merges each with a software-raised request bit, and steers every source to one of two active-high processor outputs: a fast request line or a normal request line. Sources on the normal path can be bound to sixteen programmable vector slots. Each slot carries a handler address. A lower slot index means higher urgency. Sources not bound to any enabled slot share one default handler address at a seventeenth, lowest level.

Software enters a handler by reading the vector register. That read returns the handler address of the most urgent qualifying level, raises the in-service level to it, and remembers the level it came from. Software leaves the handler by writing any value to the same register, which restores the remembered level. While a level is in service, only sources of strictly higher urgency can raise the normal output. Handlers can therefore nest.

A small bus-side state machine has two named states. RD_IDLE waits for a read. RD_HOLD lasts while the read strobe stays high. The transition RD_IDLE to RD_HOLD, taken when the strobe is first seen high, is the only point where read data is captured and the vector side effect happens. The transition RD_HOLD to RD_IDLE is taken when the strobe drops.

Top module: `vpic_top`

## Requirements
- R1: A source's raw state is its input line OR its software bit, and the raw word reads at 0x008. Writing ones to 0x018 sets software bits. Writing ones to 0x01C clears them. A read of 0x018 returns the software bits.
- R2: Writing ones to 0x010 sets enable bits and writing ones to 0x014 clears them; 0x010 reads back the enables. The normal status at 0x000 equals raw AND enable AND NOT fast-select. Writes to 0x000 have no effect.
- R3: The fast-select word is at 0x00C. The fast status at 0x004 equals raw AND fast-select. fiq_o is high exactly when the fast status is nonzero. A fast-selected source never raises irq_o.
- R4: The control byte of slot n is at 0x200+4n. Bit 5 enables the slot and bits 4:0 name its source. Slot n's address is at 0x100+4n. A source in an enabled slot n is more urgent than every slot above n and the default level. If two enabled slots name one source, the lower slot wins. A source in a disabled slot is non-vectored.
- R5: irq_o is high exactly when some normal-status source is strictly more urgent than the in-service level. The levels are slots 0 to 15, default 16 and idle 17. A non-vectored source therefore raises irq_o only at idle.
- R6: A read of 0x030 picks the most urgent level above the in-service level that has a normal-status source. It records the old level for the new one, enters the new level, and returns that slot's address, or the default address at 0x034 for level 16.
- R7: A read of 0x030 with no qualifying level returns the default address and leaves the level unchanged.
- R8: A write of any value to 0x030 restores the level recorded for the in-service level. At idle the write has no effect.
- R9: Read data appears in the cycle after bus_rd is first seen high and holds while bus_rd stays high. A held read counts as one transaction, and its vector side effect happens once.
- R10: After reset, all enables, selects, software bits, slot controls, slot addresses and the default address are zero. The level is idle, and irq_o and fiq_o are low.
- R11: Words 0xFE0 to 0xFFC return the bytes 0x56, 0x49, 0x43, 0x01, 0x0D, 0xF0, 0x05, 0xB1 in address order. Bit 0 written to 0x020 reads back there. Unmapped words read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_rd | input | 1 | Read strobe; one transaction while held high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_in | input | 32 | Level-sensitive request lines |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The hardest states to reach are deep nestings: three slots in service at once with the bus-side state machine re-entering RD_IDLE between reads. The bench raises higher-urgency sources one at a time, entering each handler with a vector read before raising the next. It then unwinds in reverse order and checks irq_o after every pop. A read held high while a more urgent source arrives shows that a second push would have suppressed irq_o. That exposes any re-trigger of the side effect.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
    localparam int NSRC   = 32;
    localparam int NSLOT  = 16;
    localparam int DW     = 32;
    localparam int AW     = 12;
    localparam int SEL_W  = $clog2(NSRC);
    localparam int SLOT_W = $clog2(NSLOT);
    localparam int LVL_W  = $clog2(NSLOT + 2);
    localparam int DEF_LVL  = NSLOT;
    localparam int IDLE_LVL = NSLOT + 1;
    localparam int CTL_EN_BIT = 5;

    localparam logic [AW-3:0] W_NSTAT = 10'h000;
    localparam logic [AW-3:0] W_FSTAT = 10'h001;
    localparam logic [AW-3:0] W_RAW   = 10'h002;
    localparam logic [AW-3:0] W_FSEL  = 10'h003;
    localparam logic [AW-3:0] W_ENSET = 10'h004;
    localparam logic [AW-3:0] W_ENCLR = 10'h005;
    localparam logic [AW-3:0] W_SWSET = 10'h006;
    localparam logic [AW-3:0] W_SWCLR = 10'h007;
    localparam logic [AW-3:0] W_PROT  = 10'h008;
    localparam logic [AW-3:0] W_VECT  = 10'h00C;
    localparam logic [AW-3:0] W_DEFV  = 10'h00D;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef enum logic {RD_IDLE, RD_HOLD} rd_state_t;
endpackage

// File: rtl/vpic_regs.sv
module vpic_regs
    import vpic_pkg::*;
#(
    parameter logic [63:0] ID_BYTES = 64'hB1_05_F0_0D_01_43_49_56
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [AW-1:0]             bus_addr,
    input  logic                      bus_wr,
    input  logic [DW-1:0]             bus_wdata,
    input  logic [NSRC-1:0]           src_in,
    input  logic                      vec_found,
    input  lvl_t                      vec_lvl,
    output logic [NSRC-1:0]           nstat,
    output logic [NSRC-1:0]           fstat,
    output logic [NSLOT-1:0][7:0]     slot_ctl,
    output logic [DW-1:0]             rd_mux
);
    logic [NSRC-1:0]            en_q, fsel_q, sw_q;
    logic                       prot_q;
    logic [DW-1:0]              defv_q;
    logic [NSLOT-1:0][DW-1:0]   slot_addr;
    logic [NSRC-1:0]            raw;
    logic [AW-3:0]              wa;
    logic                       in_addr_win, in_ctl_win, in_id_win;
    logic [DW-1:0]              vec_val;

    assign wa          = bus_addr[AW-1:2];
    assign in_addr_win = (bus_addr[AW-1:6] == 6'h04);
    assign in_ctl_win  = (bus_addr[AW-1:6] == 6'h08);
    assign in_id_win   = (bus_addr[AW-1:5] == 7'h7F);

    assign raw   = src_in | sw_q;
    assign nstat = raw & en_q & ~fsel_q;
    assign fstat = raw & fsel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= '0;
            fsel_q    <= '0;
            sw_q      <= '0;
            prot_q    <= 1'b0;
            defv_q    <= '0;
            slot_addr <= '0;
            slot_ctl  <= '0;
        end else if (bus_wr) begin
            if (in_addr_win)
                slot_addr[bus_addr[SLOT_W+1:2]] <= bus_wdata;
            else if (in_ctl_win)
                slot_ctl[bus_addr[SLOT_W+1:2]] <= bus_wdata[7:0];
            else begin
                unique case (wa)
                    W_FSEL:  fsel_q <= bus_wdata;
                    W_ENSET: en_q   <= en_q | bus_wdata;
                    W_ENCLR: en_q   <= en_q & ~bus_wdata;
                    W_SWSET: sw_q   <= sw_q | bus_wdata;
                    W_SWCLR: sw_q   <= sw_q & ~bus_wdata;
                    W_PROT:  prot_q <= bus_wdata[0];
                    W_DEFV:  defv_q <= bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        if (vec_found && (vec_lvl != lvl_t'(DEF_LVL)))
            vec_val = slot_addr[vec_lvl[SLOT_W-1:0]];
        else
            vec_val = defv_q;
    end

    always_comb begin
        rd_mux = '0;
        if (in_addr_win)
            rd_mux = slot_addr[bus_addr[SLOT_W+1:2]];
        else if (in_ctl_win)
            rd_mux = {24'h0, slot_ctl[bus_addr[SLOT_W+1:2]]};
        else if (in_id_win)
            rd_mux = {24'h0, ID_BYTES[bus_addr[4:2]*8 +: 8]};
        else begin
            unique case (wa)
                W_NSTAT: rd_mux = nstat;
                W_FSTAT: rd_mux = fstat;
                W_RAW:   rd_mux = raw;
                W_FSEL:  rd_mux = fsel_q;
                W_ENSET: rd_mux = en_q;
                W_SWSET: rd_mux = sw_q;
                W_PROT:  rd_mux = {31'h0, prot_q};
                W_VECT:  rd_mux = vec_val;
                W_DEFV:  rd_mux = defv_q;
                default: rd_mux = '0;
            endcase
        end
    end
endmodule

// File: rtl/vpic_prio.sv
module vpic_prio
    import vpic_pkg::*;
(
    input  logic [NSLOT-1:0][7:0] slot_ctl,
    input  logic [NSRC-1:0]       nstat,
    input  lvl_t                  cur_lvl,
    output logic                  irq_req,
    output logic                  vec_found,
    output lvl_t                  vec_lvl
);
    // above[k]: sources more urgent than level k
    logic [NSRC-1:0] above [NSLOT+2];

    always_comb begin
        logic [NSRC-1:0] acc;
        acc = '0;
        for (int i = 0; i < NSLOT; i++) begin
            above[i] = acc;
            if (slot_ctl[i][CTL_EN_BIT])
                acc = acc | (NSRC'(1) << slot_ctl[i][SEL_W-1:0]);
        end
        above[DEF_LVL]  = acc;
        above[IDLE_LVL] = '1;
    end

    assign irq_req = |(nstat & above[cur_lvl]);

    always_comb begin
        vec_found = 1'b0;
        vec_lvl   = cur_lvl;
        for (int i = NSLOT; i >= 0; i--) begin
            if ((lvl_t'(i) < cur_lvl) && (|(nstat & above[i+1]))) begin
                vec_found = 1'b1;
                vec_lvl   = lvl_t'(i);
            end
        end
    end
endmodule

// File: rtl/vpic_nest.sv
module vpic_nest
    import vpic_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic          vect_sel,
    input  logic          vec_found,
    input  lvl_t          vec_lvl,
    input  logic [DW-1:0] rd_mux,
    output logic [DW-1:0] bus_rdata,
    output lvl_t          cur_lvl,
    output logic          hold
);
    rd_state_t st_q, st_d;
    lvl_t      saved [NSLOT+1];
    logic      accept;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RD_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (st_q)
            RD_IDLE: st_d = bus_rd ? RD_HOLD : RD_IDLE;
            RD_HOLD: st_d = bus_rd ? RD_HOLD : RD_IDLE;
        endcase
    end

    assign accept = (st_q == RD_IDLE) && bus_rd;
    assign hold   = (st_q == RD_HOLD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            cur_lvl   <= lvl_t'(IDLE_LVL);
            for (int i = 0; i <= NSLOT; i++) saved[i] <= lvl_t'(IDLE_LVL);
        end else if (accept) begin
            bus_rdata <= rd_mux;
            if (vect_sel && vec_found) begin
                saved[vec_lvl] <= cur_lvl;
                cur_lvl        <= vec_lvl;
            end
        end else if (bus_wr && vect_sel && (cur_lvl != lvl_t'(IDLE_LVL))) begin
            cur_lvl <= saved[cur_lvl];
        end
    end
endmodule

// File: rtl/vpic_top.sv
module vpic_top
    import vpic_pkg::*;
#(
    parameter logic [63:0] ID_BYTES = 64'hB1_05_F0_0D_01_43_49_56
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NSRC-1:0] src_in,
    output logic            irq_o,
    output logic            fiq_o
);
    logic [NSRC-1:0]        nstat, fstat;
    logic [NSLOT-1:0][7:0]  slot_ctl;
    logic [DW-1:0]          rd_mux;
    logic                   vec_found, irq_req, rd_hold, vect_sel;
    lvl_t                   vec_lvl, cur_lvl;

    assign vect_sel = (bus_addr[AW-1:2] == W_VECT);

    vpic_regs #(.ID_BYTES(ID_BYTES)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .src_in(src_in), .vec_found(vec_found),
        .vec_lvl(vec_lvl), .nstat(nstat), .fstat(fstat),
        .slot_ctl(slot_ctl), .rd_mux(rd_mux)
    );

    vpic_prio u_prio (
        .slot_ctl(slot_ctl), .nstat(nstat), .cur_lvl(cur_lvl),
        .irq_req(irq_req), .vec_found(vec_found), .vec_lvl(vec_lvl)
    );

    vpic_nest u_nest (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .vect_sel(vect_sel), .vec_found(vec_found), .vec_lvl(vec_lvl),
        .rd_mux(rd_mux), .bus_rdata(bus_rdata), .cur_lvl(cur_lvl),
        .hold(rd_hold)
    );

    assign irq_o = irq_req;
    assign fiq_o = |fstat;
endmodule

// File: rtl/vpic_checker.sv
module vpic_checker
    import vpic_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          bus_rd,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_rdata,
    input logic          irq_o,
    input lvl_t          cur_lvl,
    input logic          hold
);
    AST_LVL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cur_lvl <= lvl_t'(IDLE_LVL)); // R10
    AST_HELD_LVL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        hold && bus_rd && !bus_wr |=> $stable(cur_lvl)); // R9
    AST_HELD_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        hold && bus_rd |=> $stable(bus_rdata)); // R9
    AST_READ_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && !bus_wr |=> cur_lvl <= $past(cur_lvl)); // R6
    AST_IDLE_POP: assert property (@(posedge clk) disable iff (!rst_n)
        cur_lvl == lvl_t'(IDLE_LVL) && bus_wr && !bus_rd && bus_addr[AW-1:2] == W_VECT
        |=> cur_lvl == lvl_t'(IDLE_LVL)); // R8
    AST_TOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        cur_lvl == '0 |-> !irq_o); // R5
endmodule

bind vpic_top vpic_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq_o(irq_o),
    .cur_lvl(cur_lvl), .hold(rd_hold)
);

// File: tb/tb_vpic_top.sv
`timescale 1ns/1ps
module tb_vpic_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [31:0] src_in = '0;
    logic        irq_o, fiq_o;
    int          checks = 0, errors = 0;
    logic [31:0] r;

    always #10 clk = ~clk;

    vpic_top dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_in(src_in), .irq_o(irq_o), .fiq_o(fiq_o));

    typedef struct packed {
        logic [31:0] src, en, sel, nst, fst;
        logic        irq, fiq;
    } vec_t;
    localparam int NV = 5;
    localparam vec_t TBL [NV] = '{
        '{32'h0000_0001, 32'h0000_0001, 32'h0, 32'h0000_0001, 32'h0, 1'b1, 1'b0},
        '{32'h0000_0003, 32'h0000_0002, 32'h1, 32'h0000_0002, 32'h1, 1'b1, 1'b1},
        '{32'h8000_0000, 32'h0,         32'h0, 32'h0,         32'h0, 1'b0, 1'b0},
        '{32'h0000_00F0, 32'h0000_0030, 32'h20, 32'h10,       32'h20, 1'b1, 1'b1},
        '{32'h0000_0100, 32'hFFFF_FFFF, 32'h100, 32'h0,       32'h100, 1'b0, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); d = bus_rdata; bus_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic setsrc(input logic [31:0] v);
        @(negedge clk); src_in = v; #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog act=hung exp=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        chk("R10 irq", {31'h0, irq_o}, 0);
        chk("R10 fiq", {31'h0, fiq_o}, 0);
        rd(12'h010, r); chk("R10 enable", r, 0);
        rd(12'h034, r); chk("R10 default addr", r, 0);
        rd(12'h204, r); chk("R10 slot ctl", r, 0);
        rd(12'h030, r); chk("R7 empty vect read", r, 0);
        // R11 identification and protection
        rd(12'hFE0, r); chk("R11 id first", r, 32'h56);
        rd(12'hFEC, r); chk("R11 id fourth", r, 32'h01);
        rd(12'hFFC, r); chk("R11 id last", r, 32'hB1);
        wr(12'h020, 32'hFFFF_FFFF);
        rd(12'h020, r); chk("R11 prot", r, 32'h1);
        rd(12'h0A0, r); chk("R11 unmapped", r, 0);
        // Table: R1 R2 R3 R5 at idle, no slots
        for (int k = 0; k < NV; k++) begin
            wr(12'h014, 32'hFFFF_FFFF);
            wr(12'h010, TBL[k].en);
            wr(12'h00C, TBL[k].sel);
            setsrc(TBL[k].src);
            rd(12'h000, r); chk("R2 nstat", r, TBL[k].nst);
            rd(12'h004, r); chk("R3 fstat", r, TBL[k].fst);
            rd(12'h008, r); chk("R1 raw", r, TBL[k].src);
            chk("R5 irq", {31'h0, irq_o}, {31'h0, TBL[k].irq});
            chk("R3 fiq", {31'h0, fiq_o}, {31'h0, TBL[k].fiq});
        end
        setsrc(0);
        wr(12'h00C, 0);
        // R1 software bits
        wr(12'h018, 32'h0000_0404);
        wr(12'h01C, 32'h0000_0004);
        rd(12'h018, r); chk("R1 soft read", r, 32'h400);
        rd(12'h008, r); chk("R1 soft raw", r, 32'h400);
        wr(12'h01C, 32'hFFFF_FFFF);
        // R2 status write ignored
        wr(12'h000, 32'hFFFF_FFFF);
        rd(12'h000, r); chk("R2 status write ignored", r, 0);
        rd(12'h010, r); chk("R2 enable after status write", r, 32'hFFFF_FFFF);
        // Slots R4
        wr(12'h200, 32'h25); wr(12'h100, 32'hA000);
        wr(12'h204, 32'h29); wr(12'h104, 32'hA100);
        wr(12'h208, 32'h2C); wr(12'h108, 32'hA200);
        wr(12'h20C, 32'h25); wr(12'h10C, 32'hA300);
        wr(12'h210, 32'h07); wr(12'h110, 32'hA400);
        wr(12'h034, 32'hD000);
        rd(12'h208, r); chk("R4 ctl readback", r, 32'h2C);
        // Nested three deep R6 R5
        setsrc(32'h1000);
        chk("R5 irq src12 idle", {31'h0, irq_o}, 1);
        rd(12'h030, r); chk("R6 enter slot2", r, 32'hA200);
        chk("R5 irq quiet at lvl2", {31'h0, irq_o}, 0);
        setsrc(32'h1200);
        chk("R5 irq src9 above lvl2", {31'h0, irq_o}, 1);
        rd(12'h030, r); chk("R6 enter slot1", r, 32'hA100);
        setsrc(32'h1220);
        chk("R5 irq src5 above lvl1", {31'h0, irq_o}, 1);
        rd(12'h030, r); chk("R4 dup lower slot wins", r, 32'hA000);
        chk("R5 irq quiet at lvl0", {31'h0, irq_o}, 0);
        rd(12'h030, r); chk("R7 nothing above", r, 32'hD000);
        chk("R7 level kept", {31'h0, irq_o}, 0);
        wr(12'h030, 0);
        chk("R8 pop to lvl1", {31'h0, irq_o}, 1);
        setsrc(32'h1200);
        chk("R8 lvl1 quiet", {31'h0, irq_o}, 0);
        wr(12'h030, 0);
        chk("R8 pop to lvl2", {31'h0, irq_o}, 1);
        setsrc(32'h1000);
        wr(12'h030, 0);
        chk("R8 pop to idle", {31'h0, irq_o}, 1);
        setsrc(0);
        wr(12'h030, 0);
        // non-vectored: disabled slot source 7 and source 20
        setsrc(32'h0010_0080);
        chk("R8 idle pop no effect", {31'h0, irq_o}, 1);
        rd(12'h030, r); chk("R4 disabled slot is default", r, 32'hD000);
        chk("R5 nonvectored quiet at lvl16", {31'h0, irq_o}, 0);
        setsrc(32'h0010_1080);
        chk("R5 vectored above lvl16", {31'h0, irq_o}, 1);
        wr(12'h030, 0);
        setsrc(0);
        // fast source R3
        wr(12'h00C, 32'h200);
        setsrc(32'h200);
        chk("R3 fast fiq", {31'h0, fiq_o}, 1);
        chk("R3 fast no irq", {31'h0, irq_o}, 0);
        rd(12'h030, r); chk("R3 fast not vectored", r, 32'hD000);
        setsrc(0);
        wr(12'h00C, 0);
        // held read R9
        setsrc(32'h200);
        @(negedge clk); bus_addr = 12'h030; bus_rd = 1'b1;
        @(negedge clk); src_in = 32'h220;
        repeat (3) @(negedge clk);
        chk("R9 held data", bus_rdata, 32'hA100);
        bus_rd = 1'b0;
        @(negedge clk);
        chk("R9 single push", {31'h0, irq_o}, 1);
        wr(12'h030, 0);
        setsrc(0);
        // R10 reset again clears slots
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(12'h100, r); chk("R10 slot addr cleared", r, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule